// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is the register face of a mailbox between a host processor and an auxiliary microcontroller. The host reaches it over a simple 32-bit register bus that takes only full-word accesses. It loads up to four words of input data, plus a source and a destination pointer, and then writes a command word. That write rings a one-cycle doorbell toward the controller and carries the command word with it. The block then reports busy until the controller answers.

While the command is outstanding, the controller reads the input words and pointers through its own ports. It deposits result words one per cycle into a four-word result area. It ends the exchange by pulsing done with an error flag and an 8-bit error code. The host polls the status word, or waits for the completion interrupt that the command may request. It then reads the results.

A command is accepted only while the mailbox is idle. Any host write that could disturb an outstanding command is dropped: writes to the input words, to the pointers or to the command word. A dropped command write leaves a sticky overrun mark that the host can see.

Top module: `mbox_doorbell_regs`

## Requirements
- R1: After reset the status word reads `{8'h00, 8'h00, INITIATOR_ID, 8'h00}` (0x00005A00 by default). `db_pulse` and `host_irq` are 0. Every input word, result word and pointer reads 0.
- R2: A host write with `hb_be` other than 4'hF changes nothing: no register is updated and no command is issued.
- R3: A full-word host write to byte offset 0x00 while idle takes effect one clock later. Busy (status bit 0) becomes 1, the error bit (bit 1) and the error code (bits [23:16]) read 0, and command bits [15:12] appear in status bits [7:4]. `db_pulse` is 1 for exactly that one clock, with `db_cmd` equal to the written word.
- R4: `ctl_done` while busy clears busy one clock later. It loads `ctl_err` into status bit 1 and `ctl_err_code` into status bits [23:16].
- R5: `host_irq` is 1 for one clock, in the clock after the completing `ctl_done`, if and only if bit 8 of the issued command word was 1.
- R6: While busy, host writes to the input words, to offset 0x08, to offset 0x0C and to offset 0x00 are ignored. A command write that is ignored sets status bit 2, and only reset clears that bit.
- R7: A controller write (`ctl_rbuf_we`, index `ctl_rbuf_idx`) is stored only while busy, into the result word read at byte offset 0x90 + 4·index. Host writes to 0x90–0x9C never change the result words.
- R8: Reads of offset 0x00 and of any unmapped or misaligned address return 0. Status bit 3 and bits [31:24] read 0.
- R9: Input word k (byte offset 0x80 + 4·k) and the pointers (0x08 source, 0x0C destination) read back on the host bus what was last accepted. Input word k appears on `ctl_wbuf_data` when `ctl_wbuf_idx` = k, and the pointers appear on `ctl_sptr` and `ctl_dptr`.
- R10: `ctl_done` while idle changes nothing and raises no interrupt.
- R11: A command write in the same clock as a completing `ctl_done` counts as a write while busy. It is dropped, no doorbell follows and the overrun bit is set, while the completion takes effect normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hb_req | input | 1 | Host access strobe |
| hb_we | input | 1 | Host access is a write |
| hb_addr | input | 8 | Host byte address |
| hb_wdata | input | 32 | Host write data |
| hb_be | input | 4 | Host byte enables; only 4'hF writes |
| hb_rdata | output | 32 | Host read data, same cycle as the request |
| host_irq | output | 1 | One-clock completion interrupt |
| db_pulse | output | 1 | One-clock doorbell to the controller |
| db_cmd | output | 32 | Last issued command word |
| ctl_wbuf_idx | input | 2 | Controller select of input word |
| ctl_wbuf_data | output | 32 | Selected input word |
| ctl_sptr | output | 32 | Source pointer |
| ctl_dptr | output | 32 | Destination pointer |
| ctl_rbuf_we | input | 1 | Controller result-word write strobe |
| ctl_rbuf_idx | input | 2 | Result word index |
| ctl_rbuf_data | input | 32 | Result word data |
| ctl_done | input | 1 | Controller completion strobe |
| ctl_err | input | 1 | Completion error flag |
| ctl_err_code | input | 8 | Completion error code |

## Verification
Two functions can fall in the same clock: a host command write and the controller's completion strobe. The bench provokes this by driving both in one cycle on a freshly reset mailbox with a command outstanding. It judges the result from the status word: busy clear, the error bit and code from the completion, the overrun bit set, and no doorbell in the following clock. The second case is a result-word write in the clock of completion. It is judged by reading that word back, which shows that the store made while still busy took effect.

// File: rtl/mbox_pkg.sv
// Shared constants and types for the command mailbox.
// Assumes byte addressing, word-aligned registers, and buffer bases
// aligned to the buffer size in bytes.
package mbox_pkg;
    localparam int MBOX_DATA_W = 32;
    localparam int MBOX_ADDR_W = 8;
    localparam int MBOX_WORDS  = 4;

    localparam logic [7:0] OFS_CMD  = 8'h00;
    localparam logic [7:0] OFS_STAT = 8'h04;
    localparam logic [7:0] OFS_SPTR = 8'h08;
    localparam logic [7:0] OFS_DPTR = 8'h0C;
    localparam logic [7:0] OFS_WBUF = 8'h80;

    // Command word fields
    localparam int CMD_IOC_BIT = 8;
    localparam int CMD_SUB_LSB = 12;
    localparam int CMD_SUB_W   = 4;

    typedef enum logic [2:0] {
        RG_CMD,
        RG_STAT,
        RG_SPTR,
        RG_DPTR,
        RG_WBUF,
        RG_RBUF,
        RG_NONE
    } mbox_region_e;
endpackage

// File: rtl/mbox_decode.sv
// Address decoder: maps a host byte address to a register region and a
// buffer word index. Misaligned addresses fall into RG_NONE.
// Assumes the input buffer base is aligned to WORDS*4 bytes and the result
// buffer directly follows it.
module mbox_decode
    import mbox_pkg::*;
#(
    parameter int ADDR_W = MBOX_ADDR_W,
    parameter int WORDS  = MBOX_WORDS,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic [ADDR_W-1:0] addr,
    output mbox_region_e      region,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [ADDR_W-1:0] WB_LO = ADDR_W'(OFS_WBUF);
    localparam logic [ADDR_W-1:0] RB_LO = ADDR_W'(OFS_WBUF + 4*WORDS);
    localparam logic [ADDR_W-1:0] RB_HI = ADDR_W'(OFS_WBUF + 8*WORDS);

    // Region select from the full address
    always_comb begin
        region = RG_NONE;
        if (addr[1:0] == 2'b00) begin
            if      (addr == ADDR_W'(OFS_CMD))  region = RG_CMD;
            else if (addr == ADDR_W'(OFS_STAT)) region = RG_STAT;
            else if (addr == ADDR_W'(OFS_SPTR)) region = RG_SPTR;
            else if (addr == ADDR_W'(OFS_DPTR)) region = RG_DPTR;
            else if (addr >= WB_LO && addr < RB_LO) region = RG_WBUF;
            else if (addr >= RB_LO && addr < RB_HI) region = RG_RBUF;
        end
    end

    // Word index within either buffer
    assign idx = addr[IDX_W+1:2];
endmodule

// File: rtl/mbox_status.sv
// Command handshake: accepts a command while idle, rings the doorbell,
// holds busy until the controller completes, records error, code, sub-id
// and a sticky overrun flag, and raises the completion interrupt.
// Assumes cmd_wr is already qualified by a full-word write to the command
// offset.
module mbox_status
    import mbox_pkg::*;
#(
    parameter int         DATA_W       = MBOX_DATA_W,
    parameter logic [7:0] INITIATOR_ID = 8'h5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              ctl_done,
    input  logic              ctl_err,
    input  logic [7:0]        ctl_err_code,
    output logic              busy,
    output logic [DATA_W-1:0] status_word,
    output logic              db_pulse,
    output logic [DATA_W-1:0] db_cmd,
    output logic              host_irq
);
    logic                 err_q;
    logic [7:0]           code_q;
    logic [CMD_SUB_W-1:0] sub_q;
    logic                 ioc_q;
    logic                 ovr_q;
    logic                 accept;
    logic                 finish;

    assign accept = cmd_wr && !busy;
    assign finish = ctl_done && busy;

    // Handshake state and latched command fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            err_q    <= 1'b0;
            code_q   <= '0;
            sub_q    <= '0;
            ioc_q    <= 1'b0;
            ovr_q    <= 1'b0;
            db_pulse <= 1'b0;
            db_cmd   <= '0;
            host_irq <= 1'b0;
        end else begin
            db_pulse <= accept;
            host_irq <= finish && ioc_q;
            if (cmd_wr && busy) begin
                ovr_q <= 1'b1;
            end
            if (accept) begin
                busy   <= 1'b1;
                err_q  <= 1'b0;
                code_q <= '0;
                sub_q  <= cmd_wdata[CMD_SUB_LSB +: CMD_SUB_W];
                ioc_q  <= cmd_wdata[CMD_IOC_BIT];
                db_cmd <= cmd_wdata;
            end else if (finish) begin
                busy   <= 1'b0;
                err_q  <= ctl_err;
                code_q <= ctl_err_code;
            end
        end
    end

    // Status word assembly: code, initiator, sub-id, overrun, error, busy
    assign status_word = {8'h00, code_q, INITIATOR_ID, sub_q, 1'b0, ovr_q, err_q, busy};

    AST_DB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) db_pulse |=> !db_pulse); // R3
    AST_DB_BUSY: assert property (@(posedge clk) disable iff (!rst_n) db_pulse |-> busy); // R3
    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (busy && ctl_done) |=> !busy); // R4
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) host_irq |-> $past(busy && ctl_done)); // R5
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) ovr_q |=> ovr_q); // R6
    AST_IDLE_DONE_NOP: assert property (@(posedge clk) disable iff (!rst_n) (!busy && ctl_done && !cmd_wr) |=> ($stable(err_q) && $stable(code_q) && !host_irq)); // R10
endmodule

// File: rtl/mbox_store.sv
// Data storage: input words and pointers written by the host while idle,
// result words written by the controller while busy. Provides host and
// controller read views. Assumes host write strobes are full-word already.
module mbox_store
    import mbox_pkg::*;
#(
    parameter int DATA_W = MBOX_DATA_W,
    parameter int WORDS  = MBOX_WORDS,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              wr_full,
    input  mbox_region_e      region,
    input  logic [IDX_W-1:0]  host_idx,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [IDX_W-1:0]  ctl_wbuf_idx,
    input  logic              ctl_rbuf_we,
    input  logic [IDX_W-1:0]  ctl_rbuf_idx,
    input  logic [DATA_W-1:0] ctl_rbuf_data,
    output logic [DATA_W-1:0] host_wbuf_rd,
    output logic [DATA_W-1:0] host_rbuf_rd,
    output logic [DATA_W-1:0] ctl_wbuf_data,
    output logic [DATA_W-1:0] sptr,
    output logic [DATA_W-1:0] dptr
);
    logic [DATA_W-1:0] wbuf_q [WORDS];
    logic [DATA_W-1:0] rbuf_q [WORDS];
    logic              host_ok;

    assign host_ok = wr_full && !busy;

    // Pointer registers, locked while busy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sptr <= '0;
            dptr <= '0;
        end else if (host_ok) begin
            if (region == RG_SPTR) sptr <= host_wdata;
            if (region == RG_DPTR) dptr <= host_wdata;
        end
    end

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        // Input word g, host-written while idle
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wbuf_q[g] <= '0;
            end else if (host_ok && region == RG_WBUF && host_idx == IDX_W'(g)) begin
                wbuf_q[g] <= host_wdata;
            end
        end

        // Result word g, controller-written while busy
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rbuf_q[g] <= '0;
            end else if (busy && ctl_rbuf_we && ctl_rbuf_idx == IDX_W'(g)) begin
                rbuf_q[g] <= ctl_rbuf_data;
            end
        end

        AST_WBUF_LOCK: assert property (@(posedge clk) disable iff (!rst_n) busy |=> $stable(wbuf_q[g])); // R6
        AST_RBUF_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !busy |=> $stable(rbuf_q[g])); // R7
    end

    // Read views for host and controller
    assign host_wbuf_rd  = wbuf_q[host_idx];
    assign host_rbuf_rd  = rbuf_q[host_idx];
    assign ctl_wbuf_data = wbuf_q[ctl_wbuf_idx];
endmodule

// File: rtl/mbox_doorbell_regs.sv
// Top of the command mailbox: decodes host accesses, qualifies full-word
// writes, and joins the handshake and storage units; host reads are
// combinational. Assumes a word-only host bus with a one-cycle request.
module mbox_doorbell_regs
    import mbox_pkg::*;
#(
    parameter int         DATA_W       = MBOX_DATA_W,
    parameter int         ADDR_W       = MBOX_ADDR_W,
    parameter int         WORDS        = MBOX_WORDS,
    parameter logic [7:0] INITIATOR_ID = 8'h5A,
    localparam int        IDX_W        = $clog2(WORDS),
    localparam int        BE_W         = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hb_req,
    input  logic              hb_we,
    input  logic [ADDR_W-1:0] hb_addr,
    input  logic [DATA_W-1:0] hb_wdata,
    input  logic [BE_W-1:0]   hb_be,
    output logic [DATA_W-1:0] hb_rdata,
    output logic              host_irq,
    output logic              db_pulse,
    output logic [DATA_W-1:0] db_cmd,
    input  logic [IDX_W-1:0]  ctl_wbuf_idx,
    output logic [DATA_W-1:0] ctl_wbuf_data,
    output logic [DATA_W-1:0] ctl_sptr,
    output logic [DATA_W-1:0] ctl_dptr,
    input  logic              ctl_rbuf_we,
    input  logic [IDX_W-1:0]  ctl_rbuf_idx,
    input  logic [DATA_W-1:0] ctl_rbuf_data,
    input  logic              ctl_done,
    input  logic              ctl_err,
    input  logic [7:0]        ctl_err_code
);
    mbox_region_e      region;
    logic [IDX_W-1:0]  idx;
    logic              wr_full;
    logic              busy;
    logic [DATA_W-1:0] status_word;
    logic [DATA_W-1:0] wbuf_rd;
    logic [DATA_W-1:0] rbuf_rd;

    // Only whole-word writes are qualified
    assign wr_full = hb_req && hb_we && (hb_be == '1);

    mbox_decode #(.ADDR_W(ADDR_W), .WORDS(WORDS)) u_decode (
        .addr   (hb_addr),
        .region (region),
        .idx    (idx)
    );

    mbox_status #(.DATA_W(DATA_W), .INITIATOR_ID(INITIATOR_ID)) u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_wr       (wr_full && region == RG_CMD),
        .cmd_wdata    (hb_wdata),
        .ctl_done     (ctl_done),
        .ctl_err      (ctl_err),
        .ctl_err_code (ctl_err_code),
        .busy         (busy),
        .status_word  (status_word),
        .db_pulse     (db_pulse),
        .db_cmd       (db_cmd),
        .host_irq     (host_irq)
    );

    mbox_store #(.DATA_W(DATA_W), .WORDS(WORDS)) u_store (
        .clk           (clk),
        .rst_n         (rst_n),
        .busy          (busy),
        .wr_full       (wr_full),
        .region        (region),
        .host_idx      (idx),
        .host_wdata    (hb_wdata),
        .ctl_wbuf_idx  (ctl_wbuf_idx),
        .ctl_rbuf_we   (ctl_rbuf_we),
        .ctl_rbuf_idx  (ctl_rbuf_idx),
        .ctl_rbuf_data (ctl_rbuf_data),
        .host_wbuf_rd  (wbuf_rd),
        .host_rbuf_rd  (rbuf_rd),
        .ctl_wbuf_data (ctl_wbuf_data),
        .sptr          (ctl_sptr),
        .dptr          (ctl_dptr)
    );

    // Host read mux; command word and unmapped space read as zero
    always_comb begin
        hb_rdata = '0;
        if (hb_req && !hb_we) begin
            unique case (region)
                RG_STAT: hb_rdata = status_word;
                RG_SPTR: hb_rdata = ctl_sptr;
                RG_DPTR: hb_rdata = ctl_dptr;
                RG_WBUF: hb_rdata = wbuf_rd;
                RG_RBUF: hb_rdata = rbuf_rd;
                default: hb_rdata = '0;
            endcase
        end
    end

    AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !hb_req |-> (hb_rdata == '0)); // R8
endmodule

// File: tb/mbox_doorbell_regs_tb.sv
module mbox_doorbell_regs_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam int NVEC       = 26;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hb_req = 1'b0, hb_we = 1'b0;
    logic [7:0]  hb_addr = '0;
    logic [31:0] hb_wdata = '0;
    logic [3:0]  hb_be = '0;
    logic [31:0] hb_rdata;
    logic        host_irq, db_pulse;
    logic [31:0] db_cmd, ctl_wbuf_data, ctl_sptr, ctl_dptr;
    logic [1:0]  ctl_wbuf_idx = '0, ctl_rbuf_idx = '0;
    logic        ctl_rbuf_we = 1'b0, ctl_done = 1'b0, ctl_err = 1'b0;
    logic [31:0] ctl_rbuf_data = '0;
    logic [7:0]  ctl_err_code = '0;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbox_doorbell_regs u_dut (
        .clk(clk), .rst_n(rst_n), .hb_req(hb_req), .hb_we(hb_we),
        .hb_addr(hb_addr), .hb_wdata(hb_wdata), .hb_be(hb_be),
        .hb_rdata(hb_rdata), .host_irq(host_irq), .db_pulse(db_pulse),
        .db_cmd(db_cmd), .ctl_wbuf_idx(ctl_wbuf_idx),
        .ctl_wbuf_data(ctl_wbuf_data), .ctl_sptr(ctl_sptr),
        .ctl_dptr(ctl_dptr), .ctl_rbuf_we(ctl_rbuf_we),
        .ctl_rbuf_idx(ctl_rbuf_idx), .ctl_rbuf_data(ctl_rbuf_data),
        .ctl_done(ctl_done), .ctl_err(ctl_err), .ctl_err_code(ctl_err_code)
    );

    // Vector: {is_read, req_tag[3:0], addr[7:0], data[31:0], be[3:0], expect[31:0]}
    localparam logic [80:0] VEC [NVEC] = '{
        {1'b0, 4'd9,  8'h80, 32'h1111_1111, 4'hF, 32'h0},           // R9 write word 0
        {1'b1, 4'd9,  8'h80, 32'h0,         4'h0, 32'h1111_1111},
        {1'b0, 4'd9,  8'h84, 32'h2222_2222, 4'hF, 32'h0},
        {1'b1, 4'd9,  8'h84, 32'h0,         4'h0, 32'h2222_2222},
        {1'b0, 4'd2,  8'h88, 32'hAAAA_AAAA, 4'h3, 32'h0},           // R2 partial write dropped
        {1'b1, 4'd2,  8'h88, 32'h0,         4'h0, 32'h0},
        {1'b0, 4'd9,  8'h8C, 32'h4444_4444, 4'hF, 32'h0},
        {1'b1, 4'd9,  8'h8C, 32'h0,         4'h0, 32'h4444_4444},
        {1'b0, 4'd9,  8'h08, 32'hCAFE_0008, 4'hF, 32'h0},           // R9 source pointer
        {1'b1, 4'd9,  8'h08, 32'h0,         4'h0, 32'hCAFE_0008},
        {1'b0, 4'd9,  8'h0C, 32'hDEAD_000C, 4'hF, 32'h0},           // R9 destination pointer
        {1'b1, 4'd9,  8'h0C, 32'h0,         4'h0, 32'hDEAD_000C},
        {1'b0, 4'd2,  8'h0C, 32'hFFFF_FFFF, 4'h8, 32'h0},           // R2
        {1'b1, 4'd2,  8'h0C, 32'h0,         4'h0, 32'hDEAD_000C},
        {1'b1, 4'd8,  8'h00, 32'h0,         4'h0, 32'h0},           // R8 command reads zero
        {1'b1, 4'd8,  8'h40, 32'h0,         4'h0, 32'h0},           // R8 reserved
        {1'b1, 4'd8,  8'h10, 32'h0,         4'h0, 32'h0},
        {1'b1, 4'd8,  8'h81, 32'h0,         4'h0, 32'h0},           // R8 misaligned
        {1'b1, 4'd8,  8'hA0, 32'h0,         4'h0, 32'h0},
        {1'b1, 4'd1,  8'h04, 32'h0,         4'h0, 32'h0000_5A00},   // R1 idle status
        {1'b1, 4'd1,  8'h90, 32'h0,         4'h0, 32'h0},           // R1 result word clear
        {1'b0, 4'd7,  8'h90, 32'h1234_5678, 4'hF, 32'h0},           // R7 host write to result
        {1'b1, 4'd7,  8'h90, 32'h0,         4'h0, 32'h0},
        {1'b0, 4'd2,  8'h00, 32'h0000_0101, 4'h7, 32'h0},           // R2 partial command dropped
        {1'b1, 4'd2,  8'h04, 32'h0,         4'h0, 32'h0000_5A00},
        {1'b1, 4'd2,  8'h9C, 32'h0,         4'h0, 32'h0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hwr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        hb_req = 1'b1; hb_we = 1'b1; hb_addr = a; hb_wdata = d; hb_be = be;
        @(negedge clk);
        hb_req = 1'b0; hb_we = 1'b0; hb_be = 4'h0;
    endtask

    task automatic hrd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        hb_req = 1'b1; hb_we = 1'b0; hb_addr = a;
        #1 d = hb_rdata;
        hb_req = 1'b0;
    endtask

    task automatic cdone(input logic e, input logic [7:0] c);
        @(negedge clk);
        ctl_done = 1'b1; ctl_err = e; ctl_err_code = c;
        @(negedge clk);
        ctl_done = 1'b0; ctl_err = 1'b0; ctl_err_code = '0;
    endtask

    task automatic cres(input logic [1:0] i, input logic [31:0] d);
        @(negedge clk);
        ctl_rbuf_we = 1'b1; ctl_rbuf_idx = i; ctl_rbuf_data = d;
        @(negedge clk);
        ctl_rbuf_we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset outputs
        chk("R1 db_pulse", {31'b0, db_pulse}, 32'h0);
        chk("R1 host_irq", {31'b0, host_irq}, 32'h0);
        chk("R1 sptr", ctl_sptr, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][80]) begin
                hrd(VEC[i][75:68], rd);
                chk($sformatf("R%0d vector %0d", VEC[i][79:76], i), rd, VEC[i][31:0]);
            end else begin
                hwr(VEC[i][75:68], VEC[i][67:36], VEC[i][35:32]);
            end
        end

        // R9 controller view of input words and pointers
        ctl_wbuf_idx = 2'd1;
        #1 chk("R9 ctl word1", ctl_wbuf_data, 32'h2222_2222);
        ctl_wbuf_idx = 2'd3;
        #1 chk("R9 ctl word3", ctl_wbuf_data, 32'h4444_4444);
        chk("R9 ctl sptr", ctl_sptr, 32'hCAFE_0008);
        chk("R9 ctl dptr", ctl_dptr, 32'hDEAD_000C);

        // R7 result write while idle is dropped
        cres(2'd2, 32'h7777_7777);
        hrd(8'h98, rd);
        chk("R7 idle result write", rd, 32'h0);

        // R3 issue with completion interrupt requested
        hwr(8'h00, 32'h0004_5142, 4'hF);
        chk("R3 doorbell", {31'b0, db_pulse}, 32'h1);
        chk("R3 db_cmd", db_cmd, 32'h0004_5142);
        @(negedge clk);
        chk("R3 doorbell one cycle", {31'b0, db_pulse}, 32'h0);
        hrd(8'h04, rd);
        chk("R3 busy status", rd, 32'h0000_5A51);

        // R6 writes while busy are dropped; command write marks overrun
        hwr(8'h80, 32'h9999_9999, 4'hF);
        hrd(8'h80, rd);
        chk("R6 word locked", rd, 32'h1111_1111);
        hwr(8'h08, 32'h0BAD_0BAD, 4'hF);
        hrd(8'h08, rd);
        chk("R6 pointer locked", rd, 32'hCAFE_0008);
        hwr(8'h00, 32'h0000_0001, 4'hF);
        chk("R6 no doorbell", {31'b0, db_pulse}, 32'h0);
        hrd(8'h04, rd);
        chk("R6 overrun", rd, 32'h0000_5A55);

        // R7 result words while busy
        cres(2'd2, 32'hBEEF_0002);
        cres(2'd3, 32'hBEEF_0003);
        hrd(8'h98, rd);
        chk("R7 result word2", rd, 32'hBEEF_0002);
        hrd(8'h9C, rd);
        chk("R7 result word3", rd, 32'hBEEF_0003);

        // R4 R5 completion with error
        cdone(1'b1, 8'h3C);
        chk("R5 irq", {31'b0, host_irq}, 32'h1);
        @(negedge clk);
        chk("R5 irq one cycle", {31'b0, host_irq}, 32'h0);
        hrd(8'h04, rd);
        chk("R4 done status", rd, 32'h003C_5A56);

        // R10 completion while idle
        cdone(1'b0, 8'h11);
        chk("R10 no irq", {31'b0, host_irq}, 32'h0);
        hrd(8'h04, rd);
        chk("R10 status kept", rd, 32'h003C_5A56);

        // R6 lock released once idle
        hwr(8'h80, 32'h0000_0099, 4'hF);
        hrd(8'h80, rd);
        chk("R6 unlocked", rd, 32'h0000_0099);

        // R3 R5 command without interrupt request
        hwr(8'h00, 32'h0000_2007, 4'hF);
        hrd(8'h04, rd);
        chk("R3 error cleared on issue", rd, 32'h0000_5A25);
        cdone(1'b0, 8'h00);
        chk("R5 no irq when not requested", {31'b0, host_irq}, 32'h0);
        hrd(8'h04, rd);
        chk("R4 clean completion", rd, 32'h0000_5A24);

        // R1 reset clears everything, overrun included
        do_reset();
        hrd(8'h04, rd);
        chk("R1 status after reset", rd, 32'h0000_5A00);
        hrd(8'h98, rd);
        chk("R1 result after reset", rd, 32'h0);

        // R11 command write colliding with completion
        hwr(8'h00, 32'h0000_3010, 4'hF);
        cres(2'd0, 32'h5555_0000);
        @(negedge clk);
        hb_req = 1'b1; hb_we = 1'b1; hb_addr = 8'h00; hb_wdata = 32'h0000_4020; hb_be = 4'hF;
        ctl_done = 1'b1; ctl_err = 1'b1; ctl_err_code = 8'h77;
        ctl_rbuf_we = 1'b1; ctl_rbuf_idx = 2'd1; ctl_rbuf_data = 32'h5555_0001;
        @(negedge clk);
        hb_req = 1'b0; hb_we = 1'b0; hb_be = 4'h0;
        ctl_done = 1'b0; ctl_err = 1'b0; ctl_err_code = '0; ctl_rbuf_we = 1'b0;
        chk("R11 no doorbell", {31'b0, db_pulse}, 32'h0);
        hrd(8'h04, rd);
        chk("R11 collision status", rd, 32'h0077_5A36);
        hrd(8'h94, rd);
        chk("R7 result on completion cycle", rd, 32'h5555_0001);
        hrd(8'h90, rd);
        chk("R7 result word0", rd, 32'h5555_0000);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule